// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the pins of a serial peripheral interface slave and the serial command engine behind it. It brings the chip-select, serial clock, hold and serial data pins into the system clock domain and detects their edges. From them it produces two strobes for the engine: a sample strobe on each rising serial clock and a drive strobe on each falling serial clock. It also produces the output enable for the serial data output pin.

When the host pulls the active-low hold input low, the block pauses the transfer. Both strobes stop, so the engine keeps its bit position, and the output pin is released. Serial clock and data activity are ignored until the pause ends. Entry into and exit from the pause depend on the serial clock level. A hold edge that arrives while the clock is high has its entry deferred to the next falling clock edge. A release seen while the clock is high does not resume the transfer. Chip-select is still honoured during a pause: deselecting ends the transaction, clears the pause and pulses a reset to the engine.

Top module: `spi_hold_ctrl`

## Requirements
- R1: When the synchronized hold input falls while the synchronized serial clock is low, `paused` goes to 1 within a few system clocks, with no further serial clock edge needed.
- R2: When hold falls while the serial clock is high, `paused` stays 0 until the next falling serial clock edge and then goes to 1. That falling edge produces no `drive_stb`.
- R3: A pause ends only when hold rises while the serial clock is low. A rise seen while the clock is high leaves `paused` at 1, even after the clock later goes low.
- R4: `so_oe` is 1 only when the chip is selected (`cs_n_pin` = 0), `hold_n_pin` = 1 and the block is not paused. It drops to 0 combinationally as soon as `hold_n_pin` goes low.
- R5: While paused, serial clock and data toggles produce neither `sample_stb` nor `drive_stb`.
- R6: Each rising serial clock edge while selected and not paused gives exactly one `sample_stb`, with `sample_bit` equal to the data pin level at that edge. Each falling edge in the same conditions gives one `drive_stb`. After a pause, the bit sequence continues with no bit lost or repeated.
- R7: A rise of chip-select gives a one-cycle `xfer_reset` pulse and clears any pause. While deselected, hold edges cause no pause and clock edges give no strobes.
- R8: All pins except the combinational `so_oe` path pass through a `SYNC_STAGES`-deep synchronizer before use. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| si_pin | input | 1 | Serial data input pin |
| sample_stb | output | 1 | One-cycle strobe per accepted rising serial clock |
| drive_stb | output | 1 | One-cycle strobe per accepted falling serial clock |
| sample_bit | output | 1 | Synchronized data bit, valid with `sample_stb` |
| so_oe | output | 1 | Output enable for the serial data output pin |
| paused | output | 1 | Transfer is paused |
| xfer_reset | output | 1 | One-cycle pulse returning the engine to idle on deselect |

## Verification
The hardest cases to reach are the two that depend on the clock level: a hold fall while the serial clock is high, and a hold rise while the clock is high. Each needs the pins moved in a fixed order relative to the clock phase and the synchronizer latency. The bench parks the serial clock high, waits until the synchronized level has settled, and only then moves hold. It then checks that the pause has not started (or has not ended), and checks again after the clock falls. A scoreboard of expected data bits shows that a byte split by a pause arrives whole and in order.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    HP_RUN  = 2'd0,
    HP_PEND = 2'd1,
    HP_HALT = 2'd2
  } hp_state_e;

  localparam int unsigned HP_SYNC_DEF = 2;
  localparam int unsigned HP_PIN_CNT  = 4;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hp_edge.sv
module hp_edge #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign rise[b] =  lvl[b] & ~prev_q[b];
    assign fall[b] = ~lvl[b] &  prev_q[b];
  end
endmodule

// File: rtl/hp_pause_fsm.sv
module hp_pause_fsm
  import hp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic desel,
  input  logic sck_lvl,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic hold_fall,
  input  logic hold_rise,
  output logic sample_stb,
  output logic drive_stb,
  output logic halted
);
  hp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HP_RUN: begin
        if (!desel && hold_fall) state_d = sck_lvl ? HP_PEND : HP_HALT;
      end
      HP_PEND: begin
        if (desel || hold_rise) state_d = HP_RUN;
        else if (sck_fall)      state_d = HP_HALT;
      end
      HP_HALT: begin
        if (desel)                      state_d = HP_RUN;
        else if (hold_rise && !sck_lvl) state_d = HP_RUN;
      end
      default: state_d = HP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HP_RUN;
    else        state_q <= state_d;
  end

  assign halted     = (state_q == HP_HALT);
  assign sample_stb = sck_rise & ~desel & (state_q != HP_HALT);
  assign drive_stb  = sck_fall & ~desel & (state_q == HP_RUN) & ~hold_fall;

  AST_NO_STB_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!sample_stb && !drive_stb)); // R5
  AST_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !$past(sck_lvl)); // R2
  AST_EXIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> ($past(desel) || ($past(hold_rise) && !$past(sck_lvl)))); // R3
  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !halted); // R7
  AST_DESEL_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    desel |-> (!sample_stb && !drive_stb)); // R7
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import hp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = HP_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic hold_n_pin,
  input  logic si_pin,
  output logic sample_stb,
  output logic drive_stb,
  output logic sample_bit,
  output logic so_oe,
  output logic paused,
  output logic xfer_reset
);
  localparam int unsigned PINS = HP_PIN_CNT;
  localparam logic [PINS-1:0] PIN_RST = 4'b0110;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PINS-1:0] pin_s;
  hp_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({si_pin, hold_n_pin, cs_n_pin, sck_pin}),
    .q    (pin_s)
  );

  logic sck_s, desel_s, hold_n_s, si_s;
  assign sck_s    = pin_s[0];
  assign desel_s  = pin_s[1];
  assign hold_n_s = pin_s[2];
  assign si_s     = pin_s[3];

  logic [1:0] rise_v, fall_v;
  hp_edge #(.WIDTH(2), .RST_VAL(2'b10)) i_edge (
    .clk  (clk),
    .rst_n(rst_int_n),
    .lvl  ({hold_n_s, sck_s}),
    .rise (rise_v),
    .fall (fall_v)
  );

  logic desel_prev_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) desel_prev_q <= 1'b1;
    else            desel_prev_q <= desel_s;
  end

  logic halted;
  hp_pause_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .desel     (desel_s),
    .sck_lvl   (sck_s),
    .sck_rise  (rise_v[0]),
    .sck_fall  (fall_v[0]),
    .hold_fall (fall_v[1]),
    .hold_rise (rise_v[1]),
    .sample_stb(sample_stb),
    .drive_stb (drive_stb),
    .halted    (halted)
  );

  assign sample_bit = si_s & sample_stb;
  assign paused     = halted;
  assign xfer_reset = desel_s & ~desel_prev_q;
  assign so_oe      = rst_int_n & ~desel_s & hold_n_pin & ~halted;

  AST_RESET_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    xfer_reset |=> !xfer_reset); // R7
  AST_PAUSED_NO_SO: assert property (@(posedge clk) disable iff (!rst_int_n)
    paused |-> !so_oe); // R4
endmodule

// File: tb/test_spi_hold_ctrl.sv
module test_spi_hold_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic cs_n_pin, sck_pin, hold_n_pin, si_pin;
  logic sample_stb, drive_stb, sample_bit, so_oe, paused, xfer_reset;

  always #2 clk = ~clk;

  spi_hold_ctrl i_spi_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
    .hold_n_pin(hold_n_pin), .si_pin(si_pin), .sample_stb(sample_stb),
    .drive_stb(drive_stb), .sample_bit(sample_bit), .so_oe(so_oe),
    .paused(paused), .xfer_reset(xfer_reset)
  );

  int errs = 0, checks = 0;
  int smp_cnt = 0, drv_cnt = 0, rst_cnt = 0;
  bit exp_q[$];
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one data bit, pushes the expected sampled value
  task automatic send_bit(input bit b);
    si_pin = b; wclk(6);
    sck_pin = 1'b1; exp_q.push_back(b); wclk(6);
    sck_pin = 1'b0; wclk(6);
  endtask

  task automatic toggle_ignored();
    si_pin = ~si_pin; sck_pin = 1'b1; wclk(6);
    sck_pin = 1'b0; si_pin = ~si_pin; wclk(6);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (drive_stb)  drv_cnt++;
      if (xfer_reset) rst_cnt++;
      if (sample_stb) begin
        smp_cnt++;
        if (exp_q.size() == 0) chk("R5 unexpected sample", 1, 0);
        else chk("R6 sample_bit", int'(sample_bit), int'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    int s0, d0, r0;
    cs_n_pin = 1; sck_pin = 0; hold_n_pin = 1; si_pin = 0; rst_n = 0;
    wclk(3);
    chk("R8 reset sample_stb", int'(sample_stb), 0);
    chk("R8 reset so_oe", int'(so_oe), 0);
    chk("R8 reset paused", int'(paused), 0);
    chk("R8 reset xfer_reset", int'(xfer_reset), 0);
    rst_n = 1; wclk(8);

    cs_n_pin = 0; wclk(6);
    chk("R4 so_oe selected", int'(so_oe), 1);

    // byte 0xA5 split after three bits
    d0 = drv_cnt;
    send_bit(1); send_bit(0); send_bit(1);
    chk("R6 drive strobes", drv_cnt - d0, 3);
    hold_n_pin = 0; #1;
    chk("R4 so_oe drops at once", int'(so_oe), 0);
    wclk(6);
    chk("R1 pause with sck low", int'(paused), 1);
    s0 = smp_cnt; d0 = drv_cnt;
    toggle_ignored(); toggle_ignored(); toggle_ignored();
    chk("R5 no sample while paused", smp_cnt - s0, 0);
    chk("R5 no drive while paused", drv_cnt - d0, 0);
    hold_n_pin = 1; wclk(6);
    chk("R3 resume with sck low", int'(paused), 0);
    chk("R4 so_oe after resume", int'(so_oe), 1);
    send_bit(0); send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    chk("R6 eight bits total", smp_cnt, 8);
    chk("R6 queue drained", exp_q.size(), 0);

    // deferred entry: hold falls while sck high
    si_pin = 1; wclk(2); sck_pin = 1; exp_q.push_back(1'b1); wclk(6);
    hold_n_pin = 0; wclk(6);
    chk("R2 no pause while sck high", int'(paused), 0);
    d0 = drv_cnt;
    sck_pin = 0; wclk(6);
    chk("R2 pause at falling sck", int'(paused), 1);
    chk("R2 no drive at entry fall", drv_cnt - d0, 0);

    // release while sck high does not resume
    sck_pin = 1; wclk(6);
    hold_n_pin = 1; wclk(6);
    chk("R3 rise with sck high stays paused", int'(paused), 1);
    sck_pin = 0; wclk(6);
    chk("R3 still paused after sck low", int'(paused), 1);
    chk("R4 so_oe off while paused", int'(so_oe), 0);
    hold_n_pin = 0; wclk(6); hold_n_pin = 1; wclk(6);
    chk("R3 proper release resumes", int'(paused), 0);

    // deselect during pause
    hold_n_pin = 0; wclk(6);
    chk("R1 paused again", int'(paused), 1);
    r0 = rst_cnt;
    cs_n_pin = 1; wclk(6);
    chk("R7 xfer_reset pulse", rst_cnt - r0, 1);
    chk("R7 pause cleared", int'(paused), 0);
    hold_n_pin = 1; wclk(6); hold_n_pin = 0; wclk(6);
    chk("R7 hold ignored when deselected", int'(paused), 0);
    s0 = smp_cnt; d0 = drv_cnt;
    sck_pin = 1; wclk(6); sck_pin = 0; wclk(6);
    chk("R7 no strobes deselected", (smp_cnt - s0) + (drv_cnt - d0), 0);
    hold_n_pin = 1; wclk(6);

    cs_n_pin = 0; wclk(6);
    s0 = smp_cnt;
    send_bit(1); send_bit(0);
    chk("R6 new transfer samples", smp_cnt - s0, 2);
    chk("R6 final queue empty", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule